// File: doc/BRIEF.md
# Pixel-Repeating Video Raster Timing Generator

This block runs on the pixel clock and produces the timing for a 640x480, 60 frames per second raster. Its outputs feed a parallel-RGB-to-DVI transmitter: 24-bit colour, active-low horizontal and vertical sync, a data-enable, and the horizontal and vertical position counters. Data-enable separates active video from blanking, so a black active pixel and a blanking pixel stay distinct. Serial encoding runs downstream at ten bit periods per pixel and is not part of this block.

A slow image source runs from a clock-enable at one quarter of the pixel rate. The block drives the address of the pixel it needs next, fetches the colour in the cycle the clock-enable is high, and shows that colour on four consecutive output pixels. A 160-pixel-wide image therefore fills each 640-pixel line. With line doubling selected, each source row is shown on two consecutive output lines, so a 160x240 image fills the screen. Every timing length and the repeat factor are parameters. The defaults give 800 clocks per line (640 active, 16 front porch, 96 sync, 48 back porch) and 525 lines per frame (480 active, 10 front porch, 2 sync, 33 back porch).

Top module: `vid_rep_timing`

## Requirements
- R1: While rst_ni is low, hcount_o and vcount_o are 0, de_o is 0, hsync_o and vsync_o are 1, and rgb_o is 0.
- R2: hcount_o steps by one each clock from 0 to H_TOTAL-1 and then wraps to 0. vcount_o steps by one each time hcount_o wraps, from 0 to V_TOTAL-1, and then wraps to 0. After reset is released, the first clock moves the position to (1,0).
- R3: de_o is 1 exactly when hcount_o < H_ACT and vcount_o < V_ACT.
- R4: hsync_o is 0 exactly when hcount_o is in [H_ACT+H_FP, H_ACT+H_FP+H_SYNC). vsync_o is 0 exactly when vcount_o is in [V_ACT+V_FP, V_ACT+V_FP+V_SYNC). Both are 1 otherwise.
- R5: src_ce_o is 1 exactly in the cycles where hcount_o mod REP equals REP-1. It therefore pulses once every REP clocks, through blanking as well.
- R6: While src_ce_o is 1, src_x_o equals nh/REP, where (nh,nv) is the next raster position: hcount_o+1, or 0 with the line advanced on wrap. src_y_o equals nv when line_dbl_i is 0, and nv/2 when it is 1.
- R7: On an active pixel (h,v), rgb_o equals the src_rgb_i value sampled in the src_ce_o cycle that addressed column h/REP. That value stays on all REP pixels of the group, whatever src_rgb_i does in between. The first group after reset, which had no fetch, shows 0.
- R8: rgb_o is 0 whenever de_o is 0, whatever src_rgb_i carries.
- R9: With line_dbl_i at 1, output lines 2k and 2k+1 show the same source row k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_dbl_i | input | 1 | 1 selects line doubling (source row = line/2) |
| src_rgb_i | input | 24 | Source colour for the address on src_x_o/src_y_o, sampled when src_ce_o is high |
| src_ce_o | output | 1 | Source clock-enable, one pulse every REP clocks |
| src_x_o | output | $clog2(H_TOTAL)-$clog2(REP) | Source column of the next pixel group |
| src_y_o | output | $clog2(V_TOTAL) | Source row of the next pixel group |
| rgb_o | output | 24 | Output colour, 0 in blanking |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data-enable, 1 in the active area |
| hcount_o | output | $clog2(H_TOTAL) | Horizontal position |
| vcount_o | output | $clog2(V_TOTAL) | Vertical position |

## Verification
If a position counter takes a wrong value, the error shows on the same clock. de_o and the sync edges then fall on the wrong hcount_o or vcount_o, and a broken wrap moves sync by a whole line or frame. A slip in the repeat phase or the hold register shows on rgb_o within REP clocks: the colour changes inside a group or follows the garbage driven on src_rgb_i between pulses. A fault in the row mapping for line doubling shows on the second line of the first active pair. The bench sweeps every pixel of several frames of a reduced raster, in both row modes, and compares every port on every clock.

// File: rtl/vid_rep_pkg.sv
`timescale 1ns/1ps
package vid_rep_pkg;
  localparam int RGB_W = 24;
  typedef logic [RGB_W-1:0] rgb_t;
endpackage

// File: rtl/vid_hv_counter.sv
`timescale 1ns/1ps
module vid_hv_counter #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int HW      = 10,
  parameter int VW      = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] hcnt_o,
  output logic [VW-1:0] vcnt_o,
  output logic [HW-1:0] hnext_o,
  output logic [VW-1:0] vnext_o
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          h_wrap;

  assign h_wrap  = (hcnt_q == H_LAST);
  assign hnext_o = h_wrap ? '0 : hcnt_q + 1'b1;
  assign vnext_o = !h_wrap ? vcnt_q : ((vcnt_q == V_LAST) ? '0 : vcnt_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
    end else begin
      hcnt_q <= hnext_o;
      vcnt_q <= vnext_o;
    end
  end

  assign hcnt_o = hcnt_q;
  assign vcnt_o = vcnt_q;

  // R2
  hwrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q == H_LAST |=> hcnt_q == '0);
  // R2
  hstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q != H_LAST |=> hcnt_q == $past(hcnt_q) + 1'b1);
  // R2
  vhold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcnt_q != H_LAST |=> $stable(vcnt_q));
endmodule

// File: rtl/vid_sync_decode.sv
`timescale 1ns/1ps
module vid_sync_decode #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hnext_i,
  input  logic [VW-1:0] vnext_i,
  output logic          act_next_o,
  output logic          de_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  localparam logic [HW-1:0] H_ACT_L = HW'(H_ACT);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_ACT + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_ACT_L = VW'(V_ACT);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_ACT + V_FP + V_SYNC);

  logic hs_n, vs_n;

  assign act_next_o = (hnext_i < H_ACT_L) && (vnext_i < V_ACT_L);
  assign hs_n = !((hnext_i >= HS_BEG) && (hnext_i < HS_END));
  assign vs_n = !((vnext_i >= VS_BEG) && (vnext_i < VS_END));

  // decoded one step ahead so the outputs leave a register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o    <= 1'b0;
      hsync_o <= 1'b1;
      vsync_o <= 1'b1;
    end else begin
      de_o    <= act_next_o;
      hsync_o <= hs_n;
      vsync_o <= vs_n;
    end
  end
endmodule

// File: rtl/vid_pix_repeat.sv
`timescale 1ns/1ps
module vid_pix_repeat
  import vid_rep_pkg::*;
#(
  parameter int REP = 4,
  parameter int HW  = 10,
  parameter int VW  = 10,
  parameter int RW  = 2,
  parameter int XW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [HW-1:0] hnext_i,
  input  logic [VW-1:0] vnext_i,
  input  logic          act_next_i,
  input  logic          line_dbl_i,
  input  rgb_t          src_rgb_i,
  output logic          src_ce_o,
  output logic [XW-1:0] src_x_o,
  output logic [VW-1:0] src_y_o,
  output rgb_t          rgb_o
);
  rgb_t hold_q, pix, rgb_q;
  logic grp_start;

  assign grp_start = (hnext_i[RW-1:0] == '0);
  assign src_ce_o  = grp_start;
  assign src_x_o   = hnext_i[HW-1:RW];
  assign src_y_o   = line_dbl_i ? {1'b0, vnext_i[VW-1:1]} : vnext_i;
  assign pix       = grp_start ? src_rgb_i : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      rgb_q  <= '0;
    end else begin
      hold_q <= pix;
      rgb_q  <= act_next_i ? pix : '0;
    end
  end

  assign rgb_o = rgb_q;

  // R5
  ce_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ce_o |=> !src_ce_o);
endmodule

// File: rtl/vid_rep_timing.sv
`timescale 1ns/1ps
module vid_rep_timing
  import vid_rep_pkg::*;
#(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int REP    = 4,
  parameter int H_TOTAL = H_ACT + H_FP + H_SYNC + H_BP,
  parameter int V_TOTAL = V_ACT + V_FP + V_SYNC + V_BP,
  parameter int HW = $clog2(H_TOTAL),
  parameter int VW = $clog2(V_TOTAL),
  parameter int RW = $clog2(REP),
  parameter int XW = HW - RW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_dbl_i,
  input  logic [23:0]   src_rgb_i,
  output logic          src_ce_o,
  output logic [XW-1:0] src_x_o,
  output logic [VW-1:0] src_y_o,
  output logic [23:0]   rgb_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [HW-1:0] hcount_o,
  output logic [VW-1:0] vcount_o
);
  logic [HW-1:0] hnext;
  logic [VW-1:0] vnext;
  logic          act_next;

  initial begin
    if ((1 << RW) != REP || REP < 2) $error("REP must be a power of two >= 2");
    if ((H_TOTAL % REP) != 0 || (H_ACT % REP) != 0) $error("line lengths must be multiples of REP");
  end

  vid_hv_counter #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)
  ) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hcnt_o(hcount_o), .vcnt_o(vcount_o),
    .hnext_o(hnext), .vnext_o(vnext)
  );

  vid_sync_decode #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .HW(HW), .VW(VW)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hnext_i(hnext), .vnext_i(vnext),
    .act_next_o(act_next), .de_o(de_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o)
  );

  vid_pix_repeat #(
    .REP(REP), .HW(HW), .VW(VW), .RW(RW), .XW(XW)
  ) u_pix (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hnext_i(hnext), .vnext_i(vnext), .act_next_i(act_next),
    .line_dbl_i(line_dbl_i), .src_rgb_i(src_rgb_i),
    .src_ce_o(src_ce_o), .src_x_o(src_x_o), .src_y_o(src_y_o),
    .rgb_o(rgb_o)
  );

  // R8
  blank_black_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> rgb_o == '0);
  // R7
  rep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o && $past(de_o) && (hcount_o[RW-1:0] != '0) |-> $stable(rgb_o));
  // R4
  vs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(vsync_o) |-> hcount_o == '0);
  // R5
  ce_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ce_o |=> hcount_o[RW-1:0] == '0);
endmodule

// File: tb/vid_rep_timing_tb_top.sv
`timescale 1ns/1ps
module vid_rep_timing_tb_top;
  localparam int H_ACT = 16, H_FP = 2, H_SYNC = 3, H_BP = 3;
  localparam int V_ACT = 6, V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int REP = 4;
  localparam int HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int HW = $clog2(HT), VW = $clog2(VT), XW = HW - $clog2(REP);

  logic clk = 1'b0, rst_ni = 1'b0, line_dbl_i = 1'b0;
  logic [23:0] src_rgb_i, rgb_o;
  logic src_ce_o, hsync_o, vsync_o, de_o;
  logic [XW-1:0] src_x_o;
  logic [VW-1:0] src_y_o, vcount_o;
  logic [HW-1:0] hcount_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [23:0] mk(int x, int y);
    return {8'(x * 37 + 1), 8'(y * 11 + 5), 8'(x ^ y) | 8'h80};
  endfunction

  // valid colour only on the enable; noise between pulses
  assign src_rgb_i = src_ce_o ? mk(int'(src_x_o), int'(src_y_o))
                              : (24'h5A5A5A ^ 24'(hcount_o));

  vid_rep_timing #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP), .REP(REP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .line_dbl_i(line_dbl_i), .src_rgb_i(src_rgb_i),
    .src_ce_o(src_ce_o), .src_x_o(src_x_o), .src_y_o(src_y_o), .rgb_o(rgb_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .hcount_o(hcount_o), .vcount_o(vcount_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d)", req, act, exp, hcount_o, vcount_o);
    end
  endtask

  initial begin
    int mh = 0, mv = 0, fr = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hcount", int'(hcount_o), 0);
    chk("R1 vcount", int'(vcount_o), 0);
    chk("R1 de", int'(de_o), 0);
    chk("R1 hsync", int'(hsync_o), 1);
    chk("R1 vsync", int'(vsync_o), 1);
    chk("R1 rgb", int'(rgb_o), 0);
    rst_ni = 1'b1;
    for (int cyc = 0; cyc < 8 * HT * VT; cyc++) begin
      bit dbl, act;
      int nh, nv, row, exp_rgb;
      @(posedge clk);
      mh++;
      if (mh == HT) begin
        mh = 0; mv++;
        if (mv == VT) begin mv = 0; fr++; end
      end
      @(negedge clk);
      if (fr == 3 && mv == V_ACT && mh == 0) line_dbl_i = 1'b1;
      dbl = (fr >= 4);
      act = (mh < H_ACT) && (mv < V_ACT);
      chk("R2 hcount", int'(hcount_o), mh);
      chk("R2 vcount", int'(vcount_o), mv);
      chk("R3 de", int'(de_o), int'(act));
      chk("R4 hsync", int'(hsync_o),
          int'(!(mh >= H_ACT + H_FP && mh < H_ACT + H_FP + H_SYNC)));
      chk("R4 vsync", int'(vsync_o),
          int'(!(mv >= V_ACT + V_FP && mv < V_ACT + V_FP + V_SYNC)));
      chk("R5 src_ce", int'(src_ce_o), int'((mh % REP) == REP - 1));
      if ((mh % REP) == REP - 1) begin
        nh = (mh + 1) % HT;
        nv = (nh == 0) ? (mv + 1) % VT : mv;
        chk("R6 src_x", int'(src_x_o), nh / REP);
        chk("R6 src_y", int'(src_y_o), line_dbl_i ? nv / 2 : nv);
      end
      row = dbl ? mv / 2 : mv;
      if (!act) exp_rgb = 0;
      else if (fr == 0 && mv == 0 && mh < REP) exp_rgb = 0;
      else exp_rgb = int'(mk(mh / REP, row));
      if (!act) chk("R8 rgb blank", int'(rgb_o), exp_rgb);
      else if (dbl) chk("R9 rgb doubled", int'(rgb_o), exp_rgb);
      else chk("R7 rgb repeat", int'(rgb_o), exp_rgb);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule